// File: doc/BRIEF.md
# Glitch-free selectable card clock divider

This block makes the clock for a contact card from a reference clock. A 2-bit select code picks one of four ratios: divide by 1, 2, 4 or 8. A run input from the activation sequencer turns the output on and off. The divided ratios come from a free-running 3-bit phase counter through a registered output stage. The undivided ratio passes the reference clock through a latch-based clock gate.

A new ratio or run value takes effect only at the one reference edge in eight on which the phase counter wraps. At that edge every divided output is low. A ratio change therefore never cuts a pulse short or stretches it. Starting and stopping always begin and end on a full low phase, and when stopped the output rests low.

Top module: `card_clk_divider`

## Requirements
- R1: The ratio code maps as follows: 2'b00 selects divide by 8, 2'b01 divide by 4, 2'b11 divide by 2, and 2'b10 divide by 1.
- R2: The select and run inputs are sampled only on the reference rising edge on which the 3-bit phase counter wraps from 7 to 0. This is every 8th rising edge after reset is released, counting the first edge after release as edge 1. Any change that is gone again before such an edge has no effect on the output.
- R3: When the applied run value is low, the output is low in both phases of every reference cycle.
- R4: In a divided mode of ratio N with run applied, the output changes only on reference rising edges. After edge k it is high when (k mod N) >= N/2 and low otherwise, so the duty cycle is exactly 50%.
- R5: In divide-by-1 mode with run applied, the output equals the reference clock. The enable for each reference high phase is the mode that was applied before the rising edge that opens that phase, so the enable never changes while the reference clock is high.
- R6: The divided output is low in the reference cycle that follows every wrap edge, whatever the old and new modes. As a result, at a ratio change or at start and stop no high or low phase is shorter than half a reference period, and the last old pulse and first new pulse are full width.
- R7: While reset is asserted, the output is low, the phase counter is zero and the applied run value is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 2 | Ratio code (see R1) |
| run | input | 1 | Enable from the sequencer; output rests low when off |
| card_clk | output | 1 | Clock to the card |

## Verification
The assertions assume that ratio_sel and run are synchronous to ref_clk and settle well away from its rising edge. They also assume that the phase counter is released from reset before any mode is expected to take effect. The bench drives every input change one time unit after a falling edge, so every sampled value is stable across the following rising edge. Some changes are placed mid-window to exercise the rule that only wrap-edge values count. The divide-by-1 gate latch is assumed to see a clean reference clock, which the bench provides as an ideal square wave.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PHASE_W = 3;
  localparam int MAX_DIV = 1 << PHASE_W;

  typedef logic [PHASE_W-1:0] phase_t;

  typedef enum logic [1:0] {
    RATIO_8 = 2'b00,
    RATIO_4 = 2'b01,
    RATIO_1 = 2'b10,
    RATIO_2 = 2'b11
  } ratio_e;

  // Phase bit that forms the divided clock for a ratio; the bypass ratio has none.
  function automatic logic ratio_tap(ratio_e r, phase_t p);
    case (r)
      RATIO_8: return p[PHASE_W-1];
      RATIO_4: return p[PHASE_W-2];
      RATIO_2: return p[PHASE_W-3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_bypass(ratio_e r);
    return r == RATIO_1;
  endfunction
endpackage

// File: rtl/cdiv_phase_cnt.sv
module cdiv_phase_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] phase_o,
  output logic [W-1:0] nxt_phase_o,
  output logic         wrap_o
);
  timeunit 1ns;
  timeprecision 1ps;

  assign nxt_phase_o = phase_o + W'(1);
  assign wrap_o      = &phase_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_o <= '0;
    else        phase_o <= nxt_phase_o;
  end

  // R7: counter leaves reset at zero and steps by one
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != '1) |=> (phase_o != '0));
endmodule

// File: rtl/cdiv_mode_reg.sv
module cdiv_mode_reg
  import cdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wrap_i,
  input  ratio_e sel_i,
  input  logic   run_i,
  output ratio_e act_sel_o,
  output logic   act_run_o,
  output ratio_e nxt_sel_o,
  output logic   nxt_run_o
);
  timeunit 1ns;
  timeprecision 1ps;

  assign nxt_sel_o = wrap_i ? sel_i : act_sel_o;
  assign nxt_run_o = wrap_i ? run_i : act_run_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel_o <= RATIO_8;
      act_run_o <= 1'b0;
    end else begin
      act_sel_o <= nxt_sel_o;
      act_run_o <= nxt_run_o;
    end
  end

  // R2: applied mode moves only at the wrap edge
  p_hold_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(act_sel_o));
  p_hold_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(act_run_o));
endmodule

// File: rtl/cdiv_gate1.sv
module cdiv_gate1 (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic gclk_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic en_l;

  // Transparent while the clock is low, so the enable is frozen over each high phase.
  always_latch begin
    if (!rst_n)    en_l = 1'b0;
    else if (!clk) en_l = en_i;
  end

  assign gclk_o = clk & en_l;
endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import cdiv_pkg::*;
(
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       run,
  output logic       card_clk
);
  timeunit 1ns;
  timeprecision 1ps;

  phase_t phase, nxt_phase;
  logic   wrap;
  ratio_e act_sel, nxt_sel;
  logic   act_run, nxt_run;
  logic   div_q, bypass_en, gclk;

  cdiv_phase_cnt #(.W(PHASE_W)) u_phase (
    .clk(ref_clk), .rst_n(rst_n), .phase_o(phase),
    .nxt_phase_o(nxt_phase), .wrap_o(wrap)
  );

  cdiv_mode_reg u_mode (
    .clk(ref_clk), .rst_n(rst_n), .wrap_i(wrap),
    .sel_i(ratio_e'(ratio_sel)), .run_i(run),
    .act_sel_o(act_sel), .act_run_o(act_run),
    .nxt_sel_o(nxt_sel), .nxt_run_o(nxt_run)
  );

  // Registered divided clock: glitch-free because it is a single flop output.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= nxt_run & ~is_bypass(nxt_sel) & ratio_tap(nxt_sel, nxt_phase);
  end

  assign bypass_en = act_run & is_bypass(act_sel);

  cdiv_gate1 u_gate (
    .clk(ref_clk), .rst_n(rst_n), .en_i(bypass_en), .gclk_o(gclk)
  );

  assign card_clk = gclk | div_q;

  // R6: every change lands on a low divided phase
  p_low_after_wrap_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    wrap |=> !div_q);
  // R3: stopped output stays low
  p_stop_low_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !act_run |=> !div_q);
  // R5: bypass mode leaves the divided path quiet
  p_bypass_quiet_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (act_sel == RATIO_1) |=> !div_q);
  // R4: divided output moves only while the applied mode stays put, except at wrap
  p_div_toggle_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!wrap && act_run && act_sel == RATIO_2) |=> (div_q != $past(div_q)));
endmodule

// File: tb/test_card_clk_divider.sv
module test_card_clk_divider;
  timeunit 1ns;
  timeprecision 1ps;

  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic       run = 1'b0;
  logic       card_clk;

  int n_tests = 0;
  int n_fail  = 0;
  int k = 0;
  logic [1:0] cur_sel = 2'b00;
  logic       cur_run = 1'b0;
  logic       last_hi;
  bit         done = 0;

  always #2 ref_clk = ~ref_clk;  // 250 MHz

  card_clk_divider i_card_clk_divider (
    .ref_clk(ref_clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .run(run), .card_clk(card_clk)
  );

  // {ratio code, run, length in reference cycles}
  localparam logic [7:0] VEC [10] = '{
    {2'b00, 1'b1, 5'd24}, {2'b01, 1'b1, 5'd20}, {2'b11, 1'b1, 5'd17},
    {2'b10, 1'b1, 5'd19}, {2'b00, 1'b1, 5'd16}, {2'b10, 1'b0, 5'd16},
    {2'b11, 1'b1, 5'd11}, {2'b01, 1'b0, 5'd18}, {2'b10, 1'b1, 5'd30},
    {2'b11, 1'b1, 5'd25}
  };

  function automatic int ratio_of(logic [1:0] s);
    case (s)
      2'b00: return 8;
      2'b01: return 4;
      2'b11: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic hi_window(logic [1:0] s, int edge_n);
    int n = ratio_of(s);
    if (n == 1) return 1'b0;
    return (edge_n % n) >= (n / 2);
  endfunction

  task automatic check(logic act, logic exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: card_clk=%0b expected %0b near edge %0d", tag, act, exp, k);
    end
  endtask

  task automatic check_int(int act, int exp, string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // One reference cycle: model update at the rising edge, check both phases.
  task automatic step(string tag);
    logic gate_hi, dv;
    @(posedge ref_clk);
    k++;
    gate_hi = cur_run && (cur_sel == 2'b10);
    if (k % 8 == 0) begin
      cur_sel = ratio_sel;
      cur_run = run;
    end
    dv = cur_run && hi_window(cur_sel, k);
    #1;
    last_hi = card_clk;
    check(card_clk, gate_hi | dv, tag);
    @(negedge ref_clk);
    #1;
    check(card_clk, dv, tag);
  endtask

  initial begin
    int hi_cnt;
    // R7: reset state
    repeat (3) begin
      @(posedge ref_clk); #1 check(card_clk, 1'b0, "R7");
      @(negedge ref_clk); #1 check(card_clk, 1'b0, "R7");
    end
    rst_n = 1'b1;
    repeat (10) step("R7");

    // Table walk: R1 mapping, R3 stop, R5 bypass
    foreach (VEC[i]) begin
      ratio_sel = VEC[i][7:6];
      run       = VEC[i][5];
      for (int c = 0; c < int'(VEC[i][4:0]); c++) begin
        if (!VEC[i][5])              step("R3");
        else if (VEC[i][7:6] == 2'b10) step("R5");
        else                         step("R1");
      end
    end

    // R2: short run pulse between wraps is ignored
    run = 1'b0;
    repeat (16) step("R3");
    while (k % 8 != 1) step("R2");
    ratio_sel = 2'b11; run = 1'b1;
    hi_cnt = 0;
    repeat (3) begin step("R2"); hi_cnt += int'(last_hi); end
    run = 1'b0;
    repeat (4) begin step("R2"); hi_cnt += int'(last_hi); end
    check_int(hi_cnt, 0, "R2");

    // R4: divide by 8 is high for 4 of every 8 cycles
    ratio_sel = 2'b00; run = 1'b1;
    repeat (16) step("R4");
    hi_cnt = 0;
    repeat (8) begin step("R4"); hi_cnt += int'(last_hi); end
    check_int(hi_cnt, 4, "R4");

    // R6: changes requested mid-window across all pairs of extremes
    while (k % 8 != 3) step("R6");
    ratio_sel = 2'b10;
    repeat (13) step("R6");
    ratio_sel = 2'b11;
    repeat (11) step("R6");
    ratio_sel = 2'b10;
    repeat (9) step("R6");
    run = 1'b0;
    repeat (12) step("R6");
    run = 1'b1; ratio_sel = 2'b01;
    repeat (20) step("R6");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule